// File: doc/BRIEF.md
# Floppy Drive Output Control Register

This block is the byte-wide output control register of a floppy disk controller, placed on a simple host I/O bus at address 0x3F2. Software writes one byte to choose a drive, switch spindle motors on or off, enable the DMA and interrupt path, and hold or release the controller core in reset. The byte can be read back at any time. The block turns the stored byte into registered, glitch-free pin-level outputs: active-low motor lines, active-low drive selects, a DMA/interrupt enable, and a stretched soft-reset output for the controller core.

The soft-reset output is driven by a bit of the register, but it never clears the register itself. Software therefore releases the core simply by rewriting the same byte with that bit set. A hold counter keeps the reset asserted for a minimum number of clock cycles, sized from the clock period, so that a low write followed at once by a high write still yields a valid reset pulse. A mode input selects how the DMA enable behaves: either gated by its register bit, or forced on.

Top module: `fdc_dor`

## Requirements
- R1: After hardware reset every register bit is 0 and a read returns 0x00. Both motor lines and both drive selects are high (inactive), the DMA enable is low, and the soft-reset output is high.
- R2: The register is written on a clock edge only when chip select, write strobe and address 0x3F2 are all present together. A write to any other address, or a write without chip select, leaves the stored byte unchanged.
- R3: A read at address 0x3F2 with chip select presents the stored byte on the read data port from the next clock edge. Bit layout: [7:4] motor 3..0 on, [3] DMA enable, [2] core run (0 holds the core in reset), [1:0] drive number.
- R4: Motor line i (i = 0, 1) is low exactly when register bit 4+i is 1. Bits 6 and 7 are stored and read back but drive no output.
- R5: Drive select 0 is low only when the drive field is 00 and bit 4 is 1. Drive select 1 is low only when the field is 01 and bit 5 is 1. Field values 10 and 11 leave both selects high, so at most one select is ever low.
- R6: With mode input 2'b10 (forced) the DMA enable is 1 whatever bit 3 holds. With mode 2'b00, 2'b01 or 2'b11 (gated) it equals bit 3. Bit 3 itself always stores and reads back the written value.
- R7: While bit 2 is 0 the soft-reset output is high. Writes are accepted during soft reset, and the soft reset changes no bit of the register and no other output.
- R8: Each soft-reset pulse lasts at least HOLD_CYC cycles (10 at a 10 ns clock for 100 ns), even when the release write lands on the next bus write. A bit-2 low time of L cycles gives a pulse of HOLD_CYC+L-1 cycles.
- R9: Motor, select and DMA outputs change on the second clock edge after the write edge: one edge stores the byte, the next registers the outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high hardware reset |
| bus_cs_i | input | 1 | Chip select |
| bus_addr_i | input | 16 | I/O address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe |
| bus_wdata_i | input | 8 | Write data |
| bus_rdata_o | output | 8 | Read data, registered |
| mode_i | input | 2 | DMA enable mode: 2'b10 forced, others gated |
| mtr_n_o | output | 2 | Motor on lines, active low |
| ds_n_o | output | 2 | Drive select lines, active low |
| dma_en_o | output | 1 | DMA and interrupt enable |
| ctrl_rst_o | output | 1 | Soft reset to the controller core, active high |

## Verification
Any corruption of the stored byte appears on the motor and select pins two edges after it happens, and on read data one edge after a read. A wrong drive-field decode is visible as a select that falls with its motor bit clear, or as two selects low at once. A faulty hold counter shows as a soft-reset pulse shorter than HOLD_CYC+L-1 cycles, or one that never ends, measured from the write edges. A lost or spurious write shows in the next readback.

// File: rtl/fdc_dor_pkg.sv
package fdc_dor_pkg;

  localparam int DOR_W      = 8;
  localparam int SEL_W      = 2;
  localparam int BIT_SEL_LO = 0;
  localparam int BIT_RUN    = 2;
  localparam int BIT_DMA    = 3;
  localparam int BIT_MOT_LO = 4;

  typedef enum logic [1:0] {
    MODE_GATED     = 2'b00,
    MODE_GATED_ALT = 2'b01,
    MODE_FORCED    = 2'b10,
    MODE_RSVD      = 2'b11
  } dma_mode_e;

  function automatic logic dma_effective(input logic [1:0] mode, input logic dma_bit);
    return (mode == MODE_FORCED) ? 1'b1 : dma_bit;
  endfunction

  function automatic int hold_cycles(input int clk_ns, input int min_ns);
    int raw;
    raw = (min_ns + clk_ns - 1) / clk_ns;
    return (raw < 1) ? 1 : raw;
  endfunction

endpackage

// File: rtl/fdc_dor_bus.sv
module fdc_dor_bus #(
  parameter int                ADDR_W    = 16,
  parameter int                DATA_W    = 8,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h3F2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic              wr_i,
  input  logic              rd_i,
  input  logic [DATA_W-1:0] store_i,
  output logic              wr_hit_o,
  output logic [DATA_W-1:0] rdata_o
);

  logic addr_match;
  logic rd_hit;

  assign addr_match = (addr_i == BASE_ADDR);
  assign wr_hit_o   = cs_i & wr_i & addr_match;
  assign rd_hit     = cs_i & rd_i & addr_match;

  always_ff @(posedge clk) begin
    if (rst) begin
      rdata_o <= '0;
    end else if (rd_hit) begin
      rdata_o <= store_i;
    end
  end

endmodule

// File: rtl/fdc_dor_store.sv
module fdc_dor_store #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en_i,
  input  logic [DATA_W-1:0] wdata_i,
  output logic [DATA_W-1:0] q_o
);

  // Only the hardware reset clears the byte; the soft reset never reaches here.
  always_ff @(posedge clk) begin
    if (rst) begin
      q_o <= '0;
    end else if (wr_en_i) begin
      q_o <= wdata_i;
    end
  end

endmodule

// File: rtl/fdc_dor_drive.sv
module fdc_dor_drive #(
  parameter int N_DRV = 2,
  parameter int SEL_W = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [N_DRV-1:0] mot_i,
  input  logic [SEL_W-1:0] sel_i,
  output logic [N_DRV-1:0] mtr_n_o,
  output logic [N_DRV-1:0] ds_n_o
);

  logic [N_DRV-1:0] mtr_n_d;
  logic [N_DRV-1:0] ds_n_d;

  // A select is only driven for the numbered drive whose motor is on.
  for (genvar i = 0; i < N_DRV; i++) begin : g_drv
    assign mtr_n_d[i] = ~mot_i[i];
    assign ds_n_d[i]  = ~((sel_i == SEL_W'(i)) & mot_i[i]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      mtr_n_o <= '1;
      ds_n_o  <= '1;
    end else begin
      mtr_n_o <= mtr_n_d;
      ds_n_o  <= ds_n_d;
    end
  end

endmodule

// File: rtl/fdc_dor_ctl.sv
module fdc_dor_ctl
  import fdc_dor_pkg::*;
#(
  parameter int HOLD_CYC = 10
) (
  input  logic       clk,
  input  logic       rst,
  input  logic       run_bit_i,
  input  logic       dma_bit_i,
  input  logic [1:0] mode_i,
  output logic       ctrl_rst_o,
  output logic       dma_en_o
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          req;
  logic [CW-1:0] hold_cnt;

  assign req = ~run_bit_i;

  // The counter reloads while the request is present and drains after it,
  // so the pulse covers the request plus HOLD_CYC-1 trailing cycles.
  always_ff @(posedge clk) begin
    if (rst) begin
      hold_cnt   <= CW'(HOLD_CYC - 1);
      ctrl_rst_o <= 1'b1;
      dma_en_o   <= 1'b0;
    end else begin
      if (req) begin
        hold_cnt <= CW'(HOLD_CYC - 1);
      end else if (hold_cnt != '0) begin
        hold_cnt <= hold_cnt - 1'b1;
      end
      ctrl_rst_o <= req | (hold_cnt != '0);
      dma_en_o   <= dma_effective(mode_i, dma_bit_i);
    end
  end

endmodule

// File: rtl/fdc_dor.sv
module fdc_dor
  import fdc_dor_pkg::*;
#(
  parameter int                N_DRV      = 2,
  parameter int                ADDR_W     = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR  = 'h3F2,
  parameter int                CLK_NS     = 10,
  parameter int                MIN_RST_NS = 100
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              bus_cs_i,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [DOR_W-1:0]  bus_wdata_i,
  output logic [DOR_W-1:0]  bus_rdata_o,
  input  logic [1:0]        mode_i,
  output logic [N_DRV-1:0]  mtr_n_o,
  output logic [N_DRV-1:0]  ds_n_o,
  output logic              dma_en_o,
  output logic              ctrl_rst_o
);

  localparam int HOLD_CYC = hold_cycles(CLK_NS, MIN_RST_NS);

  logic             wr_hit;
  logic [DOR_W-1:0] dor_q;

  fdc_dor_bus #(
    .ADDR_W   (ADDR_W),
    .DATA_W   (DOR_W),
    .BASE_ADDR(BASE_ADDR)
  ) u_bus (
    .clk     (clk),
    .rst     (rst),
    .cs_i    (bus_cs_i),
    .addr_i  (bus_addr_i),
    .wr_i    (bus_wr_i),
    .rd_i    (bus_rd_i),
    .store_i (dor_q),
    .wr_hit_o(wr_hit),
    .rdata_o (bus_rdata_o)
  );

  fdc_dor_store #(
    .DATA_W(DOR_W)
  ) u_store (
    .clk    (clk),
    .rst    (rst),
    .wr_en_i(wr_hit),
    .wdata_i(bus_wdata_i),
    .q_o    (dor_q)
  );

  fdc_dor_drive #(
    .N_DRV(N_DRV),
    .SEL_W(SEL_W)
  ) u_drive (
    .clk    (clk),
    .rst    (rst),
    .mot_i  (dor_q[BIT_MOT_LO +: N_DRV]),
    .sel_i  (dor_q[BIT_SEL_LO +: SEL_W]),
    .mtr_n_o(mtr_n_o),
    .ds_n_o (ds_n_o)
  );

  fdc_dor_ctl #(
    .HOLD_CYC(HOLD_CYC)
  ) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .run_bit_i (dor_q[BIT_RUN]),
    .dma_bit_i (dor_q[BIT_DMA]),
    .mode_i    (mode_i),
    .ctrl_rst_o(ctrl_rst_o),
    .dma_en_o  (dma_en_o)
  );

endmodule

// File: rtl/fdc_dor_chk.sv
module fdc_dor_chk #(
  parameter int                N_DRV     = 2,
  parameter int                ADDR_W    = 16,
  parameter logic [ADDR_W-1:0] BASE_ADDR = 'h3F2,
  parameter int                HOLD_CYC  = 10
) (
  input logic              clk,
  input logic              rst,
  input logic              cs,
  input logic              wr,
  input logic              rd,
  input logic [ADDR_W-1:0] addr,
  input logic [1:0]        mode,
  input logic [7:0]        dor,
  input logic [7:0]        rdata,
  input logic [N_DRV-1:0]  mtr_n,
  input logic [N_DRV-1:0]  ds_n,
  input logic              dma_en,
  input logic              ctrl_rst
);

  localparam int CW = $clog2(HOLD_CYC + 1);

  logic          past_ok;
  logic [CW-1:0] hi_run;
  logic          wr_seen;
  logic          rd_seen;

  assign wr_seen = cs & wr & (addr == BASE_ADDR);
  assign rd_seen = cs & rd & (addr == BASE_ADDR);

  always_ff @(posedge clk) begin
    if (rst) begin
      past_ok <= 1'b0;
      hi_run  <= CW'(HOLD_CYC);
    end else begin
      past_ok <= 1'b1;
      if (ctrl_rst) begin
        if (hi_run != CW'(HOLD_CYC)) hi_run <= hi_run + 1'b1;
      end else begin
        hi_run <= '0;
      end
    end
  end

  AST_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(wr_seen) |-> $stable(dor)); // R2

  AST_READ_BACK: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(rd_seen) |-> rdata == $past(dor)); // R3

  AST_MTR_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> mtr_n == ~$past(dor[4 +: N_DRV])); // R4

  AST_SEL_ONE: assert property (@(posedge clk) disable iff (rst)
    past_ok |-> $onehot0(~ds_n)); // R5

  for (genvar g = 0; g < N_DRV; g++) begin : g_sel
    AST_SEL_NEEDS_MTR: assert property (@(posedge clk) disable iff (rst)
      past_ok && !ds_n[g] |-> !mtr_n[g]); // R5
  end

  AST_DMA_FORCED: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) == 2'b10 |-> dma_en); // R6

  AST_DMA_GATED: assert property (@(posedge clk) disable iff (rst)
    past_ok && $past(mode) != 2'b10 |-> dma_en == $past(dor[3])); // R6

  AST_SRST_ON: assert property (@(posedge clk) disable iff (rst)
    past_ok && !$past(dor[2]) |-> ctrl_rst); // R7

  AST_SRST_MIN: assert property (@(posedge clk) disable iff (rst)
    past_ok && $fell(ctrl_rst) |-> hi_run >= CW'(HOLD_CYC)); // R8

endmodule

bind fdc_dor fdc_dor_chk #(
  .N_DRV    (N_DRV),
  .ADDR_W   (ADDR_W),
  .BASE_ADDR(BASE_ADDR),
  .HOLD_CYC (HOLD_CYC)
) u_chk (
  .clk     (clk),
  .rst     (rst),
  .cs      (bus_cs_i),
  .wr      (bus_wr_i),
  .rd      (bus_rd_i),
  .addr    (bus_addr_i),
  .mode    (mode_i),
  .dor     (dor_q),
  .rdata   (bus_rdata_o),
  .mtr_n   (mtr_n_o),
  .ds_n    (ds_n_o),
  .dma_en  (dma_en_o),
  .ctrl_rst(ctrl_rst_o)
);

// File: tb/tb_fdc_dor.sv
module tb_fdc_dor;

  localparam int          HOLD = 10;
  localparam logic [15:0] ADR  = 16'h03F2;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cs = 1'b0, wr = 1'b0, rd = 1'b0;
  logic [15:0] addr = '0;
  logic [7:0]  wdata = '0;
  logic [7:0]  rdata;
  logic [1:0]  mode = 2'b00;
  logic [1:0]  mtr_n, ds_n;
  logic        dma_en, ctrl_rst;

  always #5 clk = ~clk;

  fdc_dor dut (
    .clk(clk), .rst(rst), .bus_cs_i(cs), .bus_addr_i(addr), .bus_wr_i(wr),
    .bus_rd_i(rd), .bus_wdata_i(wdata), .bus_rdata_o(rdata), .mode_i(mode),
    .mtr_n_o(mtr_n), .ds_n_o(ds_n), .dma_en_o(dma_en), .ctrl_rst_o(ctrl_rst)
  );

  typedef struct {
    int         due;
    int         req;
    logic       chk_rd;
    logic [7:0] rd;
    logic [1:0] mtr;
    logic [1:0] ds;
    logic       dma;
  } exp_t;

  exp_t       sb_q[$];
  exp_t       mon_e;
  int         cyc = 0;
  int         checks = 0;
  int         errors = 0;
  int         run_len = 0;
  int         last_run = 0;
  logic [7:0] model = '0;
  logic [1:0] mode_m = 2'b00;

  always @(posedge clk) cyc <= cyc + 1;

  task automatic check(input int req, input string what, input logic [7:0] act,
                       input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic exp_t predict(input int req, input logic chk_rd);
    exp_t e;
    e.due    = cyc + 1;
    e.req    = req;
    e.chk_rd = chk_rd;
    e.rd     = model;
    e.mtr    = ~model[5:4];
    e.ds[0]  = ~((model[1:0] == 2'd0) & model[4]);
    e.ds[1]  = ~((model[1:0] == 2'd1) & model[5]);
    e.dma    = (mode_m == 2'b10) ? 1'b1 : model[3];
    return e;
  endfunction

  // Monitor: pops expected items when due and compares against the pins.
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].due <= cyc) begin
      mon_e = sb_q.pop_front();
      check(mon_e.req, "mtr_n", {6'b0, mtr_n}, {6'b0, mon_e.mtr});
      check(mon_e.req, "ds_n", {6'b0, ds_n}, {6'b0, mon_e.ds});
      check(mon_e.req, "dma_en", {7'b0, dma_en}, {7'b0, mon_e.dma});
      if (mon_e.chk_rd) check(mon_e.req, "rdata", rdata, mon_e.rd);
    end
  end

  // Length of the most recent completed soft-reset pulse, in cycles.
  always @(negedge clk) begin
    if (ctrl_rst) run_len++;
    else if (run_len > 0) begin
      last_run = run_len;
      run_len  = 0;
    end
  end

  // Driver tasks: called at a falling edge, return two falling edges later.
  task automatic bus_write(input logic [15:0] a, input logic [7:0] d,
                           input logic c, input int req);
    cs = c; wr = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    cs = 1'b0; wr = 1'b0;
    if (c && a == ADR) model = d;
    sb_q.push_back(predict(req, 1'b0));
    @(negedge clk);
  endtask

  task automatic bus_read(input int req);
    cs = 1'b1; rd = 1'b1; addr = ADR;
    @(negedge clk);
    cs = 1'b0; rd = 1'b0;
    sb_q.push_back(predict(req, 1'b1));
    @(negedge clk);
  endtask

  task automatic set_mode(input logic [1:0] m, input int req);
    mode = m; mode_m = m;
    @(negedge clk);
    sb_q.push_back(predict(req, 1'b0));
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finish_run();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    idle(3);
    rst = 1'b0;
    // R1: reset values on pins, soft reset held, readback zero
    check(1, "ctrl_rst after reset", {7'b0, ctrl_rst}, 8'h01);
    sb_q.push_back(predict(1, 1'b0));
    idle(1);
    bus_read(1);

    // R2: wrong address and missing chip select are ignored
    bus_write(16'h03F3, 8'hFF, 1'b1, 2);
    bus_write(ADR, 8'hFF, 1'b0, 2);
    bus_read(2);

    // R7: release the core, then the hold must run out
    bus_write(ADR, 8'h04, 1'b1, 7);
    idle(HOLD + 2);
    check(7, "ctrl_rst released", {7'b0, ctrl_rst}, 8'h00);

    // R9 R5: drive 0 with motor 0, then drive 1 with motor 1
    bus_write(ADR, 8'h1C, 1'b1, 9);
    bus_write(ADR, 8'h2D, 1'b1, 9);
    bus_read(3); // R3

    // R5: every drive field against every motor pair
    for (int s = 0; s < 4; s++) begin
      for (int m = 0; m < 4; m++) begin
        bus_write(ADR, {2'b00, m[1:0], m[0], 1'b1, s[1:0]}, 1'b1, 5);
      end
    end

    // R4: upper motor bits stored only
    bus_write(ADR, 8'hC5, 1'b1, 4);
    bus_read(4);

    // R6: forced mode overrides bit 3, bit 3 still reads back as written
    set_mode(2'b10, 6);
    bus_write(ADR, 8'h04, 1'b1, 6);
    bus_read(6);
    set_mode(2'b01, 6);
    bus_write(ADR, 8'h0C, 1'b1, 6);
    set_mode(2'b11, 6);
    set_mode(2'b00, 6);

    // R7 R8: short soft reset on consecutive writes, other bits unchanged
    bus_write(ADR, 8'h3C, 1'b1, 7);
    idle(HOLD + 3);
    bus_write(ADR, 8'h38, 1'b1, 7);
    check(7, "ctrl_rst during low bit", {7'b0, ctrl_rst}, 8'h01);
    bus_write(ADR, 8'h3C, 1'b1, 7);
    idle(HOLD + 4);
    check(8, "pulse length", last_run[7:0], 8'(HOLD + 1));
    check(8, "ctrl_rst after pulse", {7'b0, ctrl_rst}, 8'h00);
    bus_read(7);

    idle(3);
    check(9, "scoreboard drained", 8'(sb_q.size()), 8'h00);
    finish_run();
  end

endmodule